// File: doc/BRIEF.md
# Two-Bank Flash Fast-Program Command Interface

This block is the command front end of a small NOR-style flash array that is split into two banks. Bus write cycles bring in an address and a data word. The block recognises two multi-word fast program sequences: a double-word sequence and a quad-word sequence. It latches the target words and then runs a timed program operation. That operation can only clear array bits, never set them. The fast program sequences are accepted only while a high-voltage enable input is held high.

While an operation is running, a read that addresses the bank being programmed returns a status word, and a read of the other bank returns array data as usual. An operation can be paused with a suspend command and continued with a resume command. When the program operation ends cleanly, the bank goes back to plain reads. If the operation tried to raise a bit from 0 to 1, the error is kept. Reads of that bank then keep returning status until a reset command is written.

The array is a register memory organised as rows of four words, so the words of one sequence always fall in a single row. The bank of an address is its most significant address bit.

Top module: `fastprog_ctl`

## Requirements
- R1: After reset every array word reads as all ones, `busy` is low and `rdata` is zero. A read presents the addressed word on `rdata` one clock after `rd_en` is sampled.
- R2: A setup write whose low data byte is 0x50 (double-word) or 0x56 (quad-word) starts a sequence only while `hv_en` is high. With `hv_en` low, the setup write is ignored and the array is unchanged.
- R3: A double-word sequence is made of the setup write plus two word writes whose addresses differ only in bit 0. `busy` rises in the clock after the last write and stays high for exactly PROG_CYCLES clocks.
- R4: A quad-word sequence is made of the setup write plus four word writes whose addresses differ only in bits 1 and 0. The operation starts after the fifth write.
- R5: A word write that breaks the adjacency rule aborts the sequence and leaves the array unchanged. A setup write with any other low byte is ignored. In both cases the interface returns to plain reads.
- R6: During an operation, a read of the programming bank returns a status word. In that word, bit 6 is a toggle that inverts on each such read while busy, bit 5 is the error flag, and all other bits are 0. A read of the other bank returns array data.
- R7: When the operation completes, each programmed word becomes the old word ANDed with the new data. When several writes of one sequence hit the same word, their data is ANDed together first.
- R8: If the new data has a 1 where the old word has a 0, the error flag is set. Reads of that bank then keep returning status, with bit 5 set, until a write with low byte 0xF0. Other writes do not clear the error.
- R9: A write with low byte 0xB0 during an operation suspends it. `busy` drops, the array is not yet changed, and reads of that bank return array data. A write with low byte 0x30 resumes the operation, which then completes its remaining cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hv_en | input | 1 | High-voltage enable that permits fast program setup |
| wr_en | input | 1 | Bus write cycle strobe |
| rd_en | input | 1 | Bus read cycle strobe |
| addr | input | ADDR_W | Word address; the top bit selects the bank |
| wdata | input | DATA_W | Write data or command code (low byte) |
| rdata | output | DATA_W | Registered read data or status word |
| busy | output | 1 | High while a program operation is running |

## Verification
The bench builds the block with ADDR_W=5, DATA_W=16 and PROG_CYCLES=8, which gives two banks of sixteen words. With an operation this short, the bench can hold a suspension across more than a full program window and show that nothing commits early. The bench can also make repeated status reads inside one operation. The small array lets the bench reach every lane of a row, do a second program on an already written word to provoke the error flag, and run cross-bank reads, all within a few hundred clocks.

// File: rtl/fp_pkg.sv
package fp_pkg;
    typedef enum logic [2:0] {
        S_READ,
        S_LOAD,
        S_BUSY,
        S_SUSP,
        S_ERR
    } fp_state_e;

    localparam logic [7:0] CMD_DBL    = 8'h50;
    localparam logic [7:0] CMD_QUAD   = 8'h56;
    localparam logic [7:0] CMD_SUSP   = 8'hB0;
    localparam logic [7:0] CMD_RESUME = 8'h30;
    localparam logic [7:0] CMD_RESET  = 8'hF0;

    localparam int STAT_TGL = 6;
    localparam int STAT_ERR = 5;
endpackage

// File: rtl/fp_array.sv
module fp_array #(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [ADDR_W-1:0]             rd_addr,
    output logic [DATA_W-1:0]             rd_word,
    input  logic [ADDR_W-3:0]             pg_row,
    output logic [3:0][DATA_W-1:0]        pg_old,
    input  logic                          pg_we,
    input  logic [3:0]                    pg_mask,
    input  logic [3:0][DATA_W-1:0]        pg_data
);
    localparam int ROW_W = ADDR_W - 2;
    localparam int ROWS  = 1 << ROW_W;

    logic [3:0][DATA_W-1:0] mem_q [ROWS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int r = 0; r < ROWS; r++) begin
                mem_q[r] <= '1;
            end
        end else if (pg_we) begin
            for (int l = 0; l < 4; l++) begin
                if (pg_mask[l]) begin
                    mem_q[pg_row][l] <= mem_q[pg_row][l] & pg_data[l];
                end
            end
        end
    end

    assign rd_word = mem_q[rd_addr[ADDR_W-1:2]][rd_addr[1:0]];
    assign pg_old  = mem_q[pg_row];
endmodule

// File: rtl/fp_adj_chk.sv
module fp_adj_chk #(
    parameter int ADDR_W = 5
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] addr,
    input  logic              quad,
    output logic              ok
);
    logic same_row;
    logic same_pair;

    assign same_row  = (addr[ADDR_W-1:2] == base[ADDR_W-1:2]);
    assign same_pair = (addr[1] == base[1]);
    assign ok        = same_row && (quad || same_pair);
endmodule

// File: rtl/fp_err_det.sv
module fp_err_det #(
    parameter int DATA_W = 16
) (
    input  logic [3:0]              mask,
    input  logic [3:0][DATA_W-1:0]  new_data,
    input  logic [3:0][DATA_W-1:0]  old_data,
    output logic                    err
);
    logic [3:0] lane_hit;

    for (genvar g = 0; g < 4; g++) begin : g_lane
        assign lane_hit[g] = mask[g] && (|(new_data[g] & ~old_data[g]));
    end

    assign err = |lane_hit;
endmodule

// File: rtl/fastprog_ctl.sv
module fastprog_ctl
    import fp_pkg::*;
#(
    parameter int ADDR_W      = 5,
    parameter int DATA_W      = 16,
    parameter int PROG_CYCLES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hv_en,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              busy
);
    localparam int CNT_W = $clog2(PROG_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PROG_CYCLES - 1);

    typedef struct packed {
        fp_state_e              st;
        logic                   quad;
        logic [2:0]             need;
        logic                   first;
        logic [ADDR_W-1:0]      base;
        logic [3:0]             mask;
        logic [3:0][DATA_W-1:0] lanes;
        logic [CNT_W-1:0]       cnt;
        logic                   tgl;
        logic [DATA_W-1:0]      rdata;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [DATA_W-1:0]       rd_word;
    logic [3:0][DATA_W-1:0]  pg_old;
    logic                    pg_we;
    logic                    adj_ok;
    logic                    prog_err;
    logic [7:0]              cmd;
    logic [DATA_W-1:0]       status;
    logic                    prog_bank;
    fp_state_e               st_now;

    assign cmd       = wdata[7:0];
    assign prog_bank = ctl_q.base[ADDR_W-1];
    assign st_now    = ctl_q.st;

    fp_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_addr (addr),
        .rd_word (rd_word),
        .pg_row  (ctl_q.base[ADDR_W-1:2]),
        .pg_old  (pg_old),
        .pg_we   (pg_we),
        .pg_mask (ctl_q.mask),
        .pg_data (ctl_q.lanes)
    );

    fp_adj_chk #(.ADDR_W(ADDR_W)) u_adj (
        .base (ctl_q.base),
        .addr (addr),
        .quad (ctl_q.quad),
        .ok   (adj_ok)
    );

    fp_err_det #(.DATA_W(DATA_W)) u_err (
        .mask     (ctl_q.mask),
        .new_data (ctl_q.lanes),
        .old_data (pg_old),
        .err      (prog_err)
    );

    always_comb begin
        ctl_d = ctl_q;
        pg_we = 1'b0;

        status           = '0;
        status[STAT_TGL] = ctl_q.tgl;
        status[STAT_ERR] = (ctl_q.st == S_ERR);

        // read steering: the bank under operation answers with status
        if (rd_en) begin
            if ((ctl_q.st == S_BUSY || ctl_q.st == S_ERR) && addr[ADDR_W-1] == prog_bank) begin
                ctl_d.rdata = status;
                if (ctl_q.st == S_BUSY) begin
                    ctl_d.tgl = ~ctl_q.tgl;
                end
            end else begin
                ctl_d.rdata = rd_word;
            end
        end

        unique case (ctl_q.st)
            S_READ: begin
                if (wr_en && hv_en && (cmd == CMD_DBL || cmd == CMD_QUAD)) begin
                    ctl_d.st    = S_LOAD;
                    ctl_d.quad  = (cmd == CMD_QUAD);
                    ctl_d.need  = (cmd == CMD_QUAD) ? 3'd4 : 3'd2;
                    ctl_d.first = 1'b1;
                    ctl_d.mask  = '0;
                    ctl_d.lanes = '1;
                end
            end
            S_LOAD: begin
                if (wr_en) begin
                    if (ctl_q.first || adj_ok) begin
                        ctl_d.lanes[addr[1:0]] = ctl_q.lanes[addr[1:0]] & wdata;
                        ctl_d.mask[addr[1:0]]  = 1'b1;
                        if (ctl_q.first) begin
                            ctl_d.base = addr;
                        end
                        ctl_d.first = 1'b0;
                        ctl_d.need  = ctl_q.need - 3'd1;
                        if (ctl_q.need == 3'd1) begin
                            ctl_d.st  = S_BUSY;
                            ctl_d.cnt = '0;
                        end
                    end else begin
                        ctl_d.st = S_READ;
                    end
                end
            end
            S_BUSY: begin
                if (wr_en && cmd == CMD_SUSP) begin
                    ctl_d.st = S_SUSP;
                end else if (ctl_q.cnt == CNT_LAST) begin
                    pg_we    = 1'b1;
                    ctl_d.st = prog_err ? S_ERR : S_READ;
                end else begin
                    ctl_d.cnt = ctl_q.cnt + 1'b1;
                end
            end
            S_SUSP: begin
                if (wr_en && cmd == CMD_RESUME) begin
                    ctl_d.st = S_BUSY;
                end
            end
            S_ERR: begin
                if (wr_en && cmd == CMD_RESET) begin
                    ctl_d.st = S_READ;
                end
            end
            default: ctl_d.st = S_READ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign rdata = ctl_q.rdata;
    assign busy  = (ctl_q.st == S_BUSY);
endmodule

// File: rtl/fastprog_ctl_chk.sv
module fastprog_ctl_chk
    import fp_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hv_en,
    input logic              wr_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] rdata,
    input logic              busy,
    input fp_state_e         st,
    input logic              prog_bank
);
    localparam logic [DATA_W-1:0] STAT_MASK = DATA_W'((1 << STAT_TGL) | (1 << STAT_ERR));

    // R2
    setup_needs_hv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_LOAD && $past(st) == S_READ) |-> $past(hv_en));

    // R3
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(wr_en));

    // R6
    status_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && busy && addr[ADDR_W-1] == prog_bank) |=> ((rdata & ~STAT_MASK) == '0));

    // R8
    err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_ERR && !(wr_en && wdata[7:0] == CMD_RESET)) |=> (st == S_ERR));

    // R9
    susp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_SUSP && !(wr_en && wdata[7:0] == CMD_RESUME)) |=> !busy);
endmodule

bind fastprog_ctl fastprog_ctl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .hv_en     (hv_en),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .addr      (addr),
    .wdata     (wdata),
    .rdata     (rdata),
    .busy      (busy),
    .st        (st_now),
    .prog_bank (prog_bank)
);

// File: tb/tb_fastprog_ctl.sv
module tb_fastprog_ctl;
    localparam int AW = 5;
    localparam int DW = 16;
    localparam int PC = 8;
    localparam int NW = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          hv_en = 1'b1;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          busy;

    fastprog_ctl #(.ADDR_W(AW), .DATA_W(DW), .PROG_CYCLES(PC)) dut (
        .clk(clk), .rst_n(rst_n), .hv_en(hv_en), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .busy(busy)
    );

    always #5 clk = ~clk;

    int    n_chk = 0;
    int    n_fail = 0;
    int    cyc = 0;
    string cur = "R1";

    // behavioural reference model: 0 read, 1 load, 2 busy, 3 suspended, 4 error
    logic [DW-1:0] m_mem [NW];
    int            m_mode;
    int            m_need;
    bit            m_quad;
    bit            m_first;
    int            m_base;
    logic [DW-1:0] m_lane [4];
    bit            m_mask [4];
    int            m_cnt;
    bit            m_tgl;
    logic [DW-1:0] m_rdata;

    task automatic chk(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < NW; i++) m_mem[i] = '1;
        m_mode = 0; m_need = 0; m_quad = 0; m_first = 0; m_base = 0;
        m_cnt = 0; m_tgl = 0; m_rdata = '0;
        for (int l = 0; l < 4; l++) begin m_lane[l] = '1; m_mask[l] = 0; end
    endtask

    task automatic model_step();
        int a;
        int c;
        bit bad;
        a = int'(addr);
        c = int'(wdata[7:0]);
        if (rd_en) begin
            if ((m_mode == 2 || m_mode == 4) && (a / (NW / 2)) == (m_base / (NW / 2))) begin
                m_rdata = '0;
                m_rdata[6] = m_tgl;
                m_rdata[5] = (m_mode == 4);
                if (m_mode == 2) m_tgl = !m_tgl;
            end else begin
                m_rdata = m_mem[a];
            end
        end
        if (m_mode == 0) begin
            if (wr_en && hv_en && (c == 'h50 || c == 'h56)) begin
                m_mode = 1; m_quad = (c == 'h56); m_need = m_quad ? 4 : 2; m_first = 1;
                for (int l = 0; l < 4; l++) begin m_lane[l] = '1; m_mask[l] = 0; end
            end
        end else if (m_mode == 1) begin
            if (wr_en) begin
                bad = !m_first && ((a / 4 != m_base / 4) || (!m_quad && (a / 2 != m_base / 2)));
                if (bad) m_mode = 0;
                else begin
                    if (m_first) m_base = a;
                    m_first = 0;
                    m_lane[a % 4] = m_lane[a % 4] & wdata;
                    m_mask[a % 4] = 1;
                    m_need--;
                    if (m_need == 0) begin m_mode = 2; m_cnt = 0; end
                end
            end
        end else if (m_mode == 2) begin
            if (wr_en && c == 'hB0) m_mode = 3;
            else if (m_cnt == PC - 1) begin
                bad = 0;
                for (int l = 0; l < 4; l++) begin
                    if (m_mask[l]) begin
                        if ((m_lane[l] & ~m_mem[(m_base / 4) * 4 + l]) != '0) bad = 1;
                        m_mem[(m_base / 4) * 4 + l] = m_mem[(m_base / 4) * 4 + l] & m_lane[l];
                    end
                end
                m_mode = bad ? 4 : 0;
            end else m_cnt++;
        end else if (m_mode == 3) begin
            if (wr_en && c == 'h30) m_mode = 2;
        end else if (m_mode == 4) begin
            if (wr_en && c == 'hF0) m_mode = 0;
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) model_reset();
        else model_step();
    end

    // clock-by-clock comparison against the model
    always @(negedge clk) begin
        chk({cur, " busy vs model"}, {15'd0, busy}, {15'd0, m_mode == 2});
        chk({cur, " rdata vs model"}, rdata, m_rdata);
    end

    task automatic bus_wr(input int a, input logic [DW-1:0] d);
        wr_en = 1'b1; addr = AW'(a); wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input int a);
        rd_en = 1'b1; addr = AW'(a);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_fail++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    logic [DW-1:0] s1;

    initial begin
        model_reset();
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state and erased array
        chk("R1 busy after reset", {15'd0, busy}, 16'd0);
        chk("R1 rdata after reset", rdata, 16'h0000);
        bus_rd(3);
        chk("R1 erased word", rdata, 16'hFFFF);

        // R2 setup ignored without high voltage
        cur = "R2";
        hv_en = 1'b0;
        bus_wr(0, 16'h0050); bus_wr(8, 16'h0000); bus_wr(9, 16'h0000);
        hv_en = 1'b1;
        chk("R2 busy stays low", {15'd0, busy}, 16'd0);
        bus_rd(8);
        chk("R2 array unchanged", rdata, 16'hFFFF);

        // R3 double-word program and its duration
        cur = "R3";
        bus_wr(0, 16'h0050); bus_wr(4, 16'h1234); bus_wr(5, 16'hABCD);
        chk("R3 busy after third write", {15'd0, busy}, 16'd1);
        idle(PC - 1);
        chk("R3 busy at last cycle", {15'd0, busy}, 16'd1);
        idle(1);
        chk("R3 busy drops", {15'd0, busy}, 16'd0);
        bus_rd(4);
        chk("R3 word 4", rdata, 16'h1234);
        bus_rd(5);
        chk("R3 word 5", rdata, 16'hABCD);

        // R4 quad-word program, R6 steering during the operation
        cur = "R4";
        bus_wr(0, 16'h0056); bus_wr(18, 16'h0F0F); bus_wr(16, 16'h00F0);
        bus_wr(19, 16'hF000); bus_wr(17, 16'h1111);
        chk("R4 busy after fifth write", {15'd0, busy}, 16'd1);
        cur = "R6";
        bus_rd(20);
        s1 = rdata;
        chk("R6 status bits only", s1 & 16'hFF9F, 16'h0000);
        bus_rd(16);
        chk("R6 toggle inverts", s1 ^ rdata, 16'h0040);
        bus_rd(4);
        chk("R6 other bank array data", rdata, 16'h1234);
        idle(PC + 2);
        cur = "R4";
        bus_rd(16); chk("R4 lane 0", rdata, 16'h00F0);
        bus_rd(17); chk("R4 lane 1", rdata, 16'h1111);
        bus_rd(18); chk("R4 lane 2", rdata, 16'h0F0F);
        bus_rd(19); chk("R4 lane 3", rdata, 16'hF000);

        // R5 adjacency violations and unknown setup code
        cur = "R5";
        bus_wr(0, 16'h0050); bus_wr(8, 16'h0000); bus_wr(10, 16'h0000);
        chk("R5 double abort not busy", {15'd0, busy}, 16'd0);
        bus_rd(8); chk("R5 double abort array", rdata, 16'hFFFF);
        bus_wr(0, 16'h0056); bus_wr(20, 16'h0000); bus_wr(21, 16'h0000); bus_wr(24, 16'h0000);
        bus_wr(9, 16'h0000); bus_wr(9, 16'h0000);
        chk("R5 quad abort not busy", {15'd0, busy}, 16'd0);
        bus_rd(20); chk("R5 quad abort array", rdata, 16'hFFFF);
        bus_wr(0, 16'h0077); bus_wr(12, 16'h0000); bus_wr(13, 16'h0000);
        chk("R5 unknown code not busy", {15'd0, busy}, 16'd0);
        bus_rd(12); chk("R5 unknown code array", rdata, 16'hFFFF);

        // R7 repeated word in one sequence is ANDed, old AND new
        cur = "R7";
        bus_wr(0, 16'h0056); bus_wr(28, 16'hFF0F); bus_wr(28, 16'h0FFF);
        bus_wr(29, 16'h8001); bus_wr(29, 16'hFFFF);
        idle(PC + 2);
        bus_rd(28); chk("R7 combined lane", rdata, 16'h0F0F);
        bus_rd(29); chk("R7 single lane", rdata, 16'h8001);
        bus_rd(30); chk("R7 untouched lane", rdata, 16'hFFFF);

        // R8 error: raise bits on word 4, sticky status until reset
        cur = "R8";
        bus_wr(0, 16'h0050); bus_wr(4, 16'h00FF); bus_wr(5, 16'hABCD);
        idle(PC + 2);
        bus_rd(4);
        chk("R8 error flag", rdata & 16'h0020, 16'h0020);
        bus_wr(0, 16'h0050);
        bus_rd(5);
        chk("R8 still status", rdata & 16'hFF9F, 16'h0000);
        chk("R8 error kept", rdata & 16'h0020, 16'h0020);
        bus_rd(16); chk("R8 other bank data", rdata, 16'h00F0);
        bus_wr(0, 16'h00F0);
        bus_rd(4); chk("R8 bits only cleared", rdata, 16'h0034);

        // R9 suspend and resume
        cur = "R9";
        bus_wr(0, 16'h0056); bus_wr(24, 16'h0F0F); bus_wr(25, 16'h00F0);
        bus_wr(26, 16'hF000); bus_wr(27, 16'h1111);
        idle(2);
        bus_wr(0, 16'h00B0);
        chk("R9 busy low when suspended", {15'd0, busy}, 16'd0);
        idle(PC + 3);
        bus_rd(24); chk("R9 array not yet changed", rdata, 16'hFFFF);
        bus_wr(0, 16'h0030);
        chk("R9 busy after resume", {15'd0, busy}, 16'd1);
        idle(PC);
        bus_rd(24); chk("R9 word 24", rdata, 16'h0F0F);
        bus_rd(27); chk("R9 word 27", rdata, 16'h1111);

        idle(2);
        finish_run();
    end
endmodule